// File: doc/BRIEF.md
# Single-Slave Parity Serial Bus Master

This block is a register-mapped master for a reduced two-wire serial link that has exactly one power-management device on the far end. Each transfer carries one byte to or from one 8-bit register inside that device. No device address goes out on the wire, and neither side sends an acknowledge. Every byte on the wire is followed by an even-parity bit. A read is one bus access: the register address goes out and the data byte comes back in the same frame.

Software programs a register-address byte, a data byte (writes only), a length/direction word and the serial clock divider, then sets the start bit. The start bit reads back as busy until the frame ends. Completion, parity error and start-while-busy are latched as interrupt status flags. Software clears them by writing ones. A per-flag mask and a global enable gate the interrupt line. A separate 8-bit device-address field is stored for software and is never sent on the wire.

A frame is 18 bit slots: 8 address bits with their parity, then 8 data bits with their parity, most significant bit first. Each slot is one low half-period of the serial clock followed by one high half-period, and each half-period lasts divider+1 module clocks. Data changes while the clock is low and is sampled at the rising edge. The clock idles high.

Top module: `pmic_bus_master`

## Requirements
- R1: After reset, CTRL (offset 0) and ISTAT (offset 7) read 0, DIV (offset 1) reads CLK_HZ/(2*BUS_HZ)-1 (249 by default), irq is 0, sclk is 1 and sda_oe is 0. Whenever no frame is running, sclk is 1 and sda_oe is 0.
- R2: Writing CTRL with bit 0 set starts an 18-slot frame, sampled on sclk rising edges. The frame carries REGAD (offset 3) MSB first, then its even parity bit (XOR of the byte), then DATA (offset 4) MSB first, then its parity. All slots are driven (sda_oe=1) when LEN (offset 5) bit 4 is 0. No device-address slot and no acknowledge slot are sent.
- R3: When LEN bit 4 is 1 (read), slots 9 to 17 are released (sda_oe=0). The master samples sda_i at those rising edges, and at the end of the frame the received byte is stored in DATA.
- R4: CTRL bit 0 reads 1 for exactly 36*(DIV+1) module clocks after the start is accepted. At the end of the frame ISTAT bit 0 (complete) is set.
- R5: A start written while CTRL bit 0 is 1 is ignored. The running frame and its length are unchanged, and ISTAT bit 2 (load while busy) is set.
- R6: On a read, a received parity bit that does not equal the XOR of the received byte sets ISTAT bit 1 (error) together with bit 0.
- R7: Writing ISTAT clears exactly the flags whose bits are 1 in the written value. The other flags are kept.
- R8: irq is 1 exactly when CTRL bit 1 (global enable) is 1 and some ISTAT bit is set whose bit in IEN (offset 6, bits 2:0) is also set.
- R9: A start with LEN bits 3:0 not equal to 1 runs no frame: busy stays 0, sclk makes no edge, and ISTAT bit 1 is set.
- R10: DEVCFG (offset 2) holds 8 bits that read back and have no effect on the frame.
- R11: The DIV value sets the serial rate: a frame started with DIV=d lasts 36*(d+1) module clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock, idles high |
| sda_o | output | 1 | Serial data out |
| sda_oe | output | 1 | Serial data output enable |
| sda_i | input | 1 | Serial data in |

## Verification
The assertions assume that reg_wr is a single-cycle strobe with a stable offset. They also assume that sda_i changes only while sclk is low, so the value sampled at the rising edge is well defined. The bench's slave model changes sda_i only on falling sclk edges, and the register writes are driven at the falling module clock edge for exactly one cycle. The bench never writes LEN or REGAD during a frame, so the engine's latched direction is the only direction in use.

// File: rtl/pmic_pkg.sv
package pmic_pkg;
  localparam int unsigned FRAME_BITS = 18;
  localparam int unsigned RX_FIRST   = 9;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

  typedef enum logic [2:0] {
    OFS_CTRL   = 3'd0,
    OFS_DIV    = 3'd1,
    OFS_DEVCFG = 3'd2,
    OFS_REGAD  = 3'd3,
    OFS_DATA   = 3'd4,
    OFS_LEN    = 3'd5,
    OFS_IEN    = 3'd6,
    OFS_ISTAT  = 3'd7
  } reg_ofs_e;

  localparam int unsigned FLG_DONE = 0;
  localparam int unsigned FLG_ERR  = 1;
  localparam int unsigned FLG_LDB  = 2;

  function automatic logic even_par(input logic [7:0] b);
    return ^b;
  endfunction

  function automatic int unsigned half_div(input int unsigned clk_hz, input int unsigned bus_hz);
    return clk_hz / (2 * bus_hz) - 1;
  endfunction
endpackage

// File: rtl/pmic_clkdiv.sv
module pmic_clkdiv #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pmic_serial_engine.sv
module pmic_serial_engine
  import pmic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             tick,
  input  logic             rd,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             sda_i,
  output logic             busy,
  output logic             xfer_rd,
  output logic             sclk,
  output logic             sda_o,
  output logic             sda_oe,
  output logic             done,
  output logic [7:0]       rx_data,
  output logic             par_bad,
  output logic [IDX_W-1:0] bit_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] RX_IDX   = IDX_W'(RX_FIRST);

  logic [FRAME_BITS-1:0] sh;
  logic [8:0]            rx;
  logic                  hi;
  logic                  rx_slot;

  assign rx_slot = xfer_rd && (bit_idx >= RX_IDX);
  assign done    = busy && tick && hi && (bit_idx == LAST_IDX);
  assign sda_o   = sh[FRAME_BITS-1];
  assign sda_oe  = busy && !rx_slot;
  assign rx_data = rx[8:1];
  assign par_bad = xfer_rd && (even_par(rx[8:1]) != rx[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      xfer_rd <= 1'b0;
      sclk    <= 1'b1;
      hi      <= 1'b0;
      sh      <= '0;
      rx      <= '0;
      bit_idx <= '0;
    end else if (go) begin
      busy    <= 1'b1;
      xfer_rd <= rd;
      sclk    <= 1'b0;
      hi      <= 1'b0;
      bit_idx <= '0;
      rx      <= '0;
      sh      <= {addr, even_par(addr), wdata, even_par(wdata)};
    end else if (busy && tick) begin
      if (!hi) begin
        hi   <= 1'b1;
        sclk <= 1'b1;
        if (rx_slot) rx <= {rx[7:0], sda_i};
      end else begin
        hi <= 1'b0;
        if (bit_idx == LAST_IDX) begin
          busy <= 1'b0;
          sclk <= 1'b1;
        end else begin
          sclk    <= 1'b0;
          bit_idx <= bit_idx + 1'b1;
          sh      <= {sh[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/pmic_regs.sv
module pmic_regs
  import pmic_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DEF_DIV = 249
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             done,
  input  logic             xfer_rd,
  input  logic [7:0]       rx_data,
  input  logic             par_bad,
  output logic             go,
  output logic             start_bit,
  output logic             gie,
  output logic [DIV_W-1:0] div,
  output logic [7:0]       regad,
  output logic [7:0]       data,
  output logic             rd_flag,
  output logic [2:0]       ist,
  output logic             irq,
  output logic             ld_busy_ev,
  output logic             len_bad_ev
);
  logic [7:0] devcfg;
  logic [3:0] len_cnt;
  logic [2:0] ien;
  logic [2:0] ist_n;
  logic       start_req;

  assign start_req  = wr && (addr == OFS_CTRL) && wdata[0];
  assign ld_busy_ev = start_req && start_bit;
  assign len_bad_ev = start_req && !start_bit && (len_cnt != 4'd1);
  assign go         = start_req && !start_bit && (len_cnt == 4'd1);
  assign irq        = gie && |(ist & ien);

  always_comb begin
    ist_n = ist;
    if (wr && addr == OFS_ISTAT) ist_n = ist_n & ~wdata[2:0];
    if (done)                    ist_n[FLG_DONE] = 1'b1;
    if ((done && par_bad) || len_bad_ev) ist_n[FLG_ERR] = 1'b1;
    if (ld_busy_ev)              ist_n[FLG_LDB] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_bit <= 1'b0;
      gie       <= 1'b0;
      div       <= DIV_W'(DEF_DIV);
      devcfg    <= '0;
      regad     <= '0;
      data      <= '0;
      len_cnt   <= 4'd1;
      rd_flag   <= 1'b0;
      ien       <= '0;
      ist       <= '0;
    end else begin
      ist <= ist_n;
      if (go)        start_bit <= 1'b1;
      else if (done) start_bit <= 1'b0;
      if (done && xfer_rd) data <= rx_data;
      if (wr) begin
        unique case (addr)
          OFS_CTRL:   gie    <= wdata[1];
          OFS_DIV:    div    <= wdata[DIV_W-1:0];
          OFS_DEVCFG: devcfg <= wdata[7:0];
          OFS_REGAD:  regad  <= wdata[7:0];
          OFS_DATA:   if (!(done && xfer_rd)) data <= wdata[7:0];
          OFS_LEN:    begin len_cnt <= wdata[3:0]; rd_flag <= wdata[4]; end
          OFS_IEN:    ien    <= wdata[2:0];
          default:    ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_CTRL:   rdata[1:0]       = {gie, start_bit};
      OFS_DIV:    rdata[DIV_W-1:0] = div;
      OFS_DEVCFG: rdata[7:0]       = devcfg;
      OFS_REGAD:  rdata[7:0]       = regad;
      OFS_DATA:   rdata[7:0]       = data;
      OFS_LEN:    rdata[4:0]       = {rd_flag, len_cnt};
      OFS_IEN:    rdata[2:0]       = ien;
      OFS_ISTAT:  rdata[2:0]       = ist;
      default:    ;
    endcase
  end
endmodule

// File: rtl/pmic_bus_master.sv
module pmic_bus_master
  import pmic_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned BUS_HZ = 100_000,
  parameter int unsigned DIV_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        sda_o,
  output logic        sda_oe,
  input  logic        sda_i
);
  localparam int unsigned DEF_DIV = half_div(CLK_HZ, BUS_HZ);

  logic             go, start_bit, gie, rd_flag, tick, busy, xfer_rd;
  logic             done, par_bad, ld_busy_ev, len_bad_ev;
  logic [DIV_W-1:0] div;
  logic [7:0]       regad, data, rx_data;
  logic [2:0]       ist;
  logic [IDX_W-1:0] bit_idx;

  pmic_regs #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .done(done), .xfer_rd(xfer_rd), .rx_data(rx_data),
    .par_bad(par_bad), .go(go), .start_bit(start_bit), .gie(gie), .div(div),
    .regad(regad), .data(data), .rd_flag(rd_flag), .ist(ist), .irq(irq),
    .ld_busy_ev(ld_busy_ev), .len_bad_ev(len_bad_ev)
  );

  pmic_clkdiv #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .tick(tick)
  );

  pmic_serial_engine i_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .tick(tick), .rd(rd_flag),
    .addr(regad), .wdata(data), .sda_i(sda_i), .busy(busy), .xfer_rd(xfer_rd),
    .sclk(sclk), .sda_o(sda_o), .sda_oe(sda_oe), .done(done),
    .rx_data(rx_data), .par_bad(par_bad), .bit_idx(bit_idx)
  );
endmodule

// File: rtl/pmic_bus_master_chk.sv
module pmic_bus_master_chk
  import pmic_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             sclk,
  input logic             sda_oe,
  input logic             xfer_rd,
  input logic [IDX_W-1:0] bit_idx,
  input logic             done,
  input logic             par_bad,
  input logic             start_bit,
  input logic [2:0]       ist,
  input logic             gie,
  input logic             irq,
  input logic             go,
  input logic             ld_busy_ev,
  input logic             len_bad_ev
);
  localparam logic [IDX_W-1:0] RX_IDX = IDX_W'(RX_FIRST);

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && !sda_oe)); // R1
  AST_ADDR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx < RX_IDX) |-> sda_oe); // R2
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_rd && bit_idx >= RX_IDX) |-> !sda_oe); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!start_bit && ist[FLG_DONE])); // R4
  AST_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy); // R5
  AST_LDBUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ld_busy_ev |=> ist[FLG_LDB]); // R5
  AST_PARITY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && par_bad) |=> ist[FLG_ERR]); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq); // R8
  AST_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    len_bad_ev |=> (!busy && ist[FLG_ERR])); // R9
endmodule

bind pmic_bus_master pmic_bus_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .sda_oe(sda_oe),
  .xfer_rd(xfer_rd), .bit_idx(bit_idx), .done(done), .par_bad(par_bad),
  .start_bit(start_bit), .ist(ist), .gie(gie), .irq(irq), .go(go),
  .ld_busy_ev(ld_busy_ev), .len_bad_ev(len_bad_ev)
);

// File: tb/test_pmic_bus_master.sv
module test_pmic_bus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, sclk, sda_o, sda_oe;
  logic        sda_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int div_m = 249;
  int len_m = 1;
  bit gie_m = 0;
  int left = 0;
  int go_len = 0;
  bit model_go = 0;

  bit rec = 0;
  int fall_cnt = 0;
  logic [17:0] rd_frame = '0;
  logic [1:0] seen[$];

  pmic_bus_master i_pmic_bus_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk(sclk),
    .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference busy model: busy for 36*(div+1) clocks after an accepted start
  always @(posedge clk) begin
    if (model_go) left = go_len;
    else if (left > 0) left = left - 1;
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && reg_addr == 3'd0)
      chk(reg_rdata[0] === (left > 0), "R4 per-clock busy", reg_rdata[0], left > 0);
  end

  always @(posedge sclk) if (rec) seen.push_back({sda_oe, sda_o});

  always @(negedge sclk) if (rec) begin
    if (fall_cnt >= 9 && fall_cnt <= 17) sda_i = rd_frame[17 - fall_cnt];
    fall_cnt++;
  end

  // called at a falling clock edge, returns at the next one
  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 3'd1) div_m = int'(d[15:0]);
    if (a == 3'd5) len_m = int'(d[3:0]);
    if (a == 3'd0) begin
      gie_m = d[1];
      if (d[0] && left == 0 && len_m == 1) begin
        model_go = 1'b1; go_len = 36 * (div_m + 1);
      end
    end
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd0; model_go = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata; reg_addr = 3'd0;
    @(negedge clk);
  endtask

  task automatic run_xfer(input bit rd, input logic [7:0] ad, input logic [7:0] wd,
                          input logic [7:0] sb, input bit badpar, input bit poke,
                          output int cyc);
    logic [17:0] ef;
    int bad;
    wr_reg(3'd3, {24'd0, ad});
    if (!rd) wr_reg(3'd4, {24'd0, wd});
    wr_reg(3'd5, rd ? 32'h11 : 32'h01);
    rd_frame = {10'd0, sb} << 1;
    rd_frame[0] = badpar ? ~(^sb) : ^sb;
    seen.delete(); fall_cnt = 0; rec = 1;
    wr_reg(3'd0, {30'd0, gie_m, 1'b1});
    cyc = 0;
    forever begin
      #2;
      if (!reg_rdata[0]) break;
      cyc++;
      if (poke && cyc == 5) wr_reg(3'd0, {30'd0, gie_m, 1'b1});
      else @(negedge clk);
    end
    @(negedge clk);
    rec = 0;
    ef = {ad, ^ad, wd, ^wd};
    bad = 0;
    for (int k = 0; k < 18; k++) begin
      if (k >= seen.size()) bad++;
      else if (rd && k >= 9) begin if (seen[k][1] !== 1'b0) bad++; end
      else if (seen[k] !== {1'b1, ef[17-k]}) bad++;
    end
    chk(seen.size() == 18, rd ? "R3 slot count" : "R2 slot count", seen.size(), 18);
    chk(bad == 0, rd ? "R3 frame contents" : "R2 frame contents", bad, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cyc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_reg(3'd0, v); chk(v == 0, "R1 CTRL", v, 0);
    rd_reg(3'd7, v); chk(v == 0, "R1 ISTAT", v, 0);
    rd_reg(3'd1, v); chk(v == 249, "R1 DIV default", v, 249);
    chk(irq == 0 && sclk == 1 && sda_oe == 0, "R1 lines", {irq, sclk, sda_oe}, 3'b010);

    wr_reg(3'd1, 32'd1);
    // R10 device address field
    wr_reg(3'd2, 32'h1A5);
    rd_reg(3'd2, v); chk(v == 32'hA5, "R10 DEVCFG readback", v, 32'hA5);

    // R2 write frame, R4 duration
    run_xfer(0, 8'h3C, 8'h5A, 8'h00, 0, 0, cyc);
    chk(cyc == 72, "R4 busy length div=1", cyc, 72);
    rd_reg(3'd7, v); chk(v == 1, "R4 complete flag", v, 1);
    chk(irq == 0, "R8 irq masked by gie", irq, 0);
    wr_reg(3'd7, 32'h1);
    rd_reg(3'd7, v); chk(v == 0, "R7 clear complete", v, 0);

    // R3 read frame
    run_xfer(1, 8'h81, 8'h00, 8'hC3, 0, 0, cyc);
    rd_reg(3'd4, v); chk(v == 32'hC3, "R3 received byte", v, 32'hC3);
    rd_reg(3'd7, v); chk(v == 1, "R6 no error on good parity", v, 1);
    wr_reg(3'd7, 32'h7);

    // R6 parity error
    run_xfer(1, 8'h07, 8'h00, 8'h96, 1, 0, cyc);
    rd_reg(3'd7, v); chk(v == 3, "R6 error and complete", v, 3);
    wr_reg(3'd7, 32'h2);
    rd_reg(3'd7, v); chk(v == 1, "R7 partial clear", v, 1);
    wr_reg(3'd7, 32'h1);
    rd_reg(3'd7, v); chk(v == 0, "R7 clear rest", v, 0);

    // R8 interrupt gating
    wr_reg(3'd6, 32'h1);
    wr_reg(3'd0, 32'h2);
    chk(irq == 0, "R8 no flag no irq", irq, 0);
    run_xfer(0, 8'hF0, 8'h0F, 8'h00, 0, 0, cyc);
    chk(irq == 1, "R8 irq on enabled flag", irq, 1);
    wr_reg(3'd0, 32'h0);
    chk(irq == 0, "R8 gie off", irq, 0);
    wr_reg(3'd0, 32'h2);
    chk(irq == 1, "R8 gie back on", irq, 1);
    wr_reg(3'd7, 32'h1);
    chk(irq == 0, "R8 irq after clear", irq, 0);
    wr_reg(3'd6, 32'h4);
    wr_reg(3'd0, 32'h0);

    // R5 start while busy
    wr_reg(3'd1, 32'd2);
    run_xfer(0, 8'h55, 8'hAA, 8'h00, 0, 1, cyc);
    chk(cyc == 108, "R5 length unchanged", cyc, 108);
    rd_reg(3'd7, v); chk(v == 5, "R5 load-busy flag", v, 5);
    wr_reg(3'd7, 32'h7);

    // R9 bad length
    wr_reg(3'd5, 32'h2);
    fall_cnt = 0; rec = 1;
    wr_reg(3'd0, 32'h1);
    repeat (20) @(negedge clk);
    rec = 0;
    chk(fall_cnt == 0, "R9 no sclk activity", fall_cnt, 0);
    rd_reg(3'd0, v); chk(v[0] == 0, "R9 not busy", v[0], 0);
    rd_reg(3'd7, v); chk(v == 2, "R9 error flag", v, 2);
    wr_reg(3'd7, 32'h7);

    // R11 other divider
    wr_reg(3'd1, 32'd3);
    run_xfer(0, 8'h12, 8'h34, 8'h00, 0, 0, cyc);
    chk(cyc == 144, "R11 busy length div=3", cyc, 144);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule